// File: doc/BRIEF.md
# Radio Task/Event Sequencer

This block is the control state machine of a packet radio. Software, or the shortcut logic, issues single-cycle task strobes: transmit enable, receive enable, start, stop, disable and clear-channel start. The sequencer walks through ramp-up, idle, active and disabling states for either direction. It reports progress as sticky event flags and as one interrupt line that is gated per event. The analog front end, modulation and packet memory transfer lie outside the block. Stub datapath strobes stand in for them: end of packet, channel clear and channel busy. Ramp-up timing comes from an internal counter.

A shortcut register links chosen events to tasks. The event that fires in one cycle issues the linked task on the next clock edge, so a full sequence can run without software. One example is listen, assess the channel, turn around to transmit and send. An event that is consumed by a shortcut still sets its flag, and software has to clear that flag.

Top module: `radio_seq`

## Requirements
- R1: After reset, state_o is 0 (off) and the event flags, the interrupt enables, the shortcut register and irq_o are all zero.
- R2: Receive enable issued while off enters receive ramp-up (1). After RAMP_CYCLES cycles the block enters receive idle (2) and sets the ready flag (bit 0) and the receive-ready flag (bit 22). Start then moves it to receive active (3). End of packet in receive active returns it to receive idle and sets the end flag (bit 3).
- R3: Transmit enable follows the same path through transmit ramp-up (9), transmit idle (10) and transmit active (11). It sets the ready flag and the transmit-ready flag (bit 21), and end of packet sets the end flag.
- R4: state_o only ever holds one of the codes 0, 1, 2, 3, 4, 9, 10, 11 or 12.
- R5: Disable issued in any ramp-up, idle or active state moves the block to 4 (receive side) or 12 (transmit side) for exactly one cycle. The block then enters off (0) and sets the disabled flag (bit 4).
- R6: Stop in either active state returns the block to the idle state of that direction and sets no end flag.
- R7: Flags stay set until a 1 is written to the matching bit of evt_clr_i. When an event and a clear hit the same bit in the same cycle, the event wins.
- R8: Interrupt enables exist only at bits 0, 3, 4, 17, 18, 21 and 22. inten_set_i sets them, inten_clr_i clears them, and set wins when both act on a bit at once. irq_o is high whenever an enabled flag is set.
- R9: The shortcut register holds bits 0 (ready→start), 1 (end→disable), 2 (disabled→transmit enable), 3 (disabled→receive enable), 5 (end→start), 11 (receive-ready→clear-channel start), 12 (channel-clear→transmit enable) and 19 (transmit-ready→start). It reads back only those bits. The linked task is issued on the clock edge after the event.
- R10: An event that triggers a shortcut still sets its flag.
- R11: Clear-channel start in receive idle or active begins an assessment. A busy strobe then sets bit 18 and a clear strobe sets bit 17, with busy winning if both arrive together. Result strobes with no assessment running are ignored, and leaving the receive states drops a running assessment.
- R12: Disable takes priority over every other task, and transmit enable takes priority over receive enable. Transmit enable is also accepted in receive idle and receive active, where it turns the block around to transmit ramp-up.
- R13: A task with no meaning in the current state leaves the state and the flags unchanged. Examples are start, stop or clear-channel start while off, and receive enable in transmit idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| task_txen_i | input | 1 | Transmit enable task strobe |
| task_rxen_i | input | 1 | Receive enable task strobe |
| task_start_i | input | 1 | Start task strobe |
| task_stop_i | input | 1 | Stop task strobe |
| task_disable_i | input | 1 | Disable task strobe |
| task_ccastart_i | input | 1 | Clear-channel assessment start strobe |
| pkt_done_i | input | 1 | Packet finished, from the datapath stub |
| cca_idle_i | input | 1 | Assessment result: channel clear |
| cca_busy_i | input | 1 | Assessment result: channel busy |
| short_we_i | input | 1 | Shortcut register write strobe |
| short_wdata_i | input | 32 | Shortcut register write data |
| short_o | output | 32 | Shortcut register readback |
| inten_set_i | input | 32 | Write-1-to-set interrupt enables |
| inten_clr_i | input | 32 | Write-1-to-clear interrupt enables |
| inten_o | output | 32 | Interrupt enable readback |
| evt_clr_i | input | 32 | Write-1-to-clear event flags |
| evt_o | output | 32 | Sticky event flags |
| irq_o | output | 1 | Combined interrupt |
| state_o | output | 4 | Current state code |

## Verification
The receive and transmit paths are run with the ramp length swept cycle by cycle, so a ramp that ends one cycle early or late shows up. The tests also cover disable from each phase, the task priority collisions and tasks that have no meaning in the current state. The interrupt enables are swept over all 32 bit positions and checked against flag patterns computed in the bench, which separates the implemented bits from the unused ones and checks the set-wins rule. Three shortcut chains are timed edge by edge: ready to start, end to disable to receive enable, and the full listen, assess, turn around and send sequence. These chains show whether a chained task lands exactly one edge after its event while the event's flag still stays set.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
  localparam int EV_W     = 32;
  localparam int NUM_TASK = 6;
  localparam int NUM_SC   = 8;

  typedef enum logic [3:0] {
    ST_OFF      = 4'd0,
    ST_RX_RAMP  = 4'd1,
    ST_RX_IDLE  = 4'd2,
    ST_RX_ACT   = 4'd3,
    ST_RX_STOP  = 4'd4,
    ST_TX_RAMP  = 4'd9,
    ST_TX_IDLE  = 4'd10,
    ST_TX_ACT   = 4'd11,
    ST_TX_STOP  = 4'd12
  } rs_state_e;

  // task vector indices
  localparam int TK_TXEN  = 0;
  localparam int TK_RXEN  = 1;
  localparam int TK_START = 2;
  localparam int TK_STOP  = 3;
  localparam int TK_DIS   = 4;
  localparam int TK_CCA   = 5;

  // event / interrupt-enable bit positions
  localparam int EV_READY    = 0;
  localparam int EV_END      = 3;
  localparam int EV_DISABLED = 4;
  localparam int EV_CCAIDLE  = 17;
  localparam int EV_CCABUSY  = 18;
  localparam int EV_TXREADY  = 21;
  localparam int EV_RXREADY  = 22;

  localparam logic [EV_W-1:0] EV_MASK =
    (EV_W'(1) << EV_READY)   | (EV_W'(1) << EV_END)     |
    (EV_W'(1) << EV_DISABLED)| (EV_W'(1) << EV_CCAIDLE) |
    (EV_W'(1) << EV_CCABUSY) | (EV_W'(1) << EV_TXREADY) |
    (EV_W'(1) << EV_RXREADY);

  // shortcut table: register bit, source event, target task
  localparam int SC_BIT  [NUM_SC] = '{0, 1, 2, 3, 5, 11, 12, 19};
  localparam int SC_EV   [NUM_SC] = '{EV_READY, EV_END, EV_DISABLED, EV_DISABLED,
                                      EV_END, EV_RXREADY, EV_CCAIDLE, EV_TXREADY};
  localparam int SC_TASK [NUM_SC] = '{TK_START, TK_DIS, TK_TXEN, TK_RXEN,
                                      TK_START, TK_CCA, TK_TXEN, TK_START};

  function automatic logic [EV_W-1:0] sc_mask_f();
    logic [EV_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SC; i++) m[SC_BIT[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [EV_W-1:0] SC_MASK = sc_mask_f();
endpackage

// File: rtl/radio_seq_fsm.sv
module radio_seq_fsm
  import radio_seq_pkg::*;
#(
  parameter int RAMP_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TASK-1:0] task_i,
  input  logic                pkt_done_i,
  input  logic                cca_idle_i,
  input  logic                cca_busy_i,
  output rs_state_e           state_o,
  output logic [EV_W-1:0]     ev_o
);
  localparam int CNT_W = (RAMP_CYCLES < 2) ? 1 : $clog2(RAMP_CYCLES);
  localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(RAMP_CYCLES - 1);

  rs_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cca_q, cca_d;
  logic             rx_side;

  assign rx_side = (st_q == ST_RX_IDLE) || (st_q == ST_RX_ACT);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cca_d = cca_q;
    ev_o  = '0;

    if (rx_side && cca_q) begin
      if (cca_busy_i) begin
        ev_o[EV_CCABUSY] = 1'b1;
        cca_d = 1'b0;
      end else if (cca_idle_i) begin
        ev_o[EV_CCAIDLE] = 1'b1;
        cca_d = 1'b0;
      end
    end else if (rx_side && task_i[TK_CCA]) begin
      cca_d = 1'b1;
    end

    unique case (st_q)
      ST_OFF: begin
        if (task_i[TK_TXEN]) begin
          st_d = ST_TX_RAMP; cnt_d = '0;
        end else if (task_i[TK_RXEN]) begin
          st_d = ST_RX_RAMP; cnt_d = '0;
        end
      end
      ST_RX_RAMP, ST_TX_RAMP: begin
        if (task_i[TK_DIS]) begin
          st_d = (st_q == ST_RX_RAMP) ? ST_RX_STOP : ST_TX_STOP;
        end else if (cnt_q == RAMP_LAST) begin
          ev_o[EV_READY] = 1'b1;
          if (st_q == ST_RX_RAMP) begin
            st_d = ST_RX_IDLE; ev_o[EV_RXREADY] = 1'b1;
          end else begin
            st_d = ST_TX_IDLE; ev_o[EV_TXREADY] = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RX_IDLE: begin
        if (task_i[TK_DIS])        st_d = ST_RX_STOP;
        else if (task_i[TK_TXEN])  begin st_d = ST_TX_RAMP; cnt_d = '0; end
        else if (task_i[TK_START]) st_d = ST_RX_ACT;
      end
      ST_RX_ACT: begin
        if (task_i[TK_DIS])        st_d = ST_RX_STOP;
        else if (task_i[TK_TXEN])  begin st_d = ST_TX_RAMP; cnt_d = '0; end
        else if (pkt_done_i)       begin st_d = ST_RX_IDLE; ev_o[EV_END] = 1'b1; end
        else if (task_i[TK_STOP])  st_d = ST_RX_IDLE;
      end
      ST_TX_IDLE: begin
        if (task_i[TK_DIS])        st_d = ST_TX_STOP;
        else if (task_i[TK_START]) st_d = ST_TX_ACT;
      end
      ST_TX_ACT: begin
        if (task_i[TK_DIS])        st_d = ST_TX_STOP;
        else if (pkt_done_i)       begin st_d = ST_TX_IDLE; ev_o[EV_END] = 1'b1; end
        else if (task_i[TK_STOP])  st_d = ST_TX_IDLE;
      end
      ST_RX_STOP, ST_TX_STOP: begin
        st_d = ST_OFF;
        ev_o[EV_DISABLED] = 1'b1;
      end
      default: st_d = ST_OFF;
    endcase

    // assessment only survives inside the receive states
    if (st_d != ST_RX_IDLE && st_d != ST_RX_ACT) cca_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      cca_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cca_q <= cca_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/radio_seq_shorts.sv
module radio_seq_shorts
  import radio_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [EV_W-1:0]     wdata_i,
  input  logic [EV_W-1:0]     ev_i,
  output logic [EV_W-1:0]     short_o,
  output logic [NUM_TASK-1:0] task_o
);
  logic [EV_W-1:0]   short_q;
  logic [EV_W-1:0]   ev_q;
  logic [NUM_SC-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      short_q <= '0;
      ev_q    <= '0;
    end else begin
      if (we_i) short_q <= wdata_i & SC_MASK;
      ev_q <= ev_i;
    end
  end

  for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
    assign hit[g] = short_q[SC_BIT[g]] & ev_q[SC_EV[g]];
  end

  always_comb begin
    task_o = '0;
    for (int i = 0; i < NUM_SC; i++)
      if (hit[i]) task_o[SC_TASK[i]] = 1'b1;
  end

  assign short_o = short_q;
endmodule

// File: rtl/radio_seq_irq.sv
module radio_seq_irq
  import radio_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] ev_i,
  input  logic [EV_W-1:0] evt_clr_i,
  input  logic [EV_W-1:0] en_set_i,
  input  logic [EV_W-1:0] en_clr_i,
  output logic [EV_W-1:0] flags_o,
  output logic [EV_W-1:0] inten_o,
  output logic            irq_o
);
  for (genvar g = 0; g < EV_W; g++) begin : g_bit
    if (EV_MASK[g]) begin : g_impl
      logic f_q, e_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          f_q <= 1'b0;
          e_q <= 1'b0;
        end else begin
          if (ev_i[g])           f_q <= 1'b1;
          else if (evt_clr_i[g]) f_q <= 1'b0;
          if (en_set_i[g])       e_q <= 1'b1;
          else if (en_clr_i[g])  e_q <= 1'b0;
        end
      end
      assign flags_o[g] = f_q;
      assign inten_o[g] = e_q;
    end else begin : g_none
      assign flags_o[g] = 1'b0;
      assign inten_o[g] = 1'b0;
    end
  end

  assign irq_o = |(flags_o & inten_o);
endmodule

// File: rtl/radio_seq.sv
module radio_seq
  import radio_seq_pkg::*;
#(
  parameter int RAMP_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        task_txen_i,
  input  logic        task_rxen_i,
  input  logic        task_start_i,
  input  logic        task_stop_i,
  input  logic        task_disable_i,
  input  logic        task_ccastart_i,
  input  logic        pkt_done_i,
  input  logic        cca_idle_i,
  input  logic        cca_busy_i,
  input  logic        short_we_i,
  input  logic [31:0] short_wdata_i,
  output logic [31:0] short_o,
  input  logic [31:0] inten_set_i,
  input  logic [31:0] inten_clr_i,
  output logic [31:0] inten_o,
  input  logic [31:0] evt_clr_i,
  output logic [31:0] evt_o,
  output logic        irq_o,
  output logic [3:0]  state_o
);
  logic [NUM_TASK-1:0] ext_task, sc_task, eff_task;
  logic [EV_W-1:0]     ev;
  rs_state_e           st;

  always_comb begin
    ext_task           = '0;
    ext_task[TK_TXEN]  = task_txen_i;
    ext_task[TK_RXEN]  = task_rxen_i;
    ext_task[TK_START] = task_start_i;
    ext_task[TK_STOP]  = task_stop_i;
    ext_task[TK_DIS]   = task_disable_i;
    ext_task[TK_CCA]   = task_ccastart_i;
  end

  assign eff_task = ext_task | sc_task;

  radio_seq_fsm #(.RAMP_CYCLES(RAMP_CYCLES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .task_i     (eff_task),
    .pkt_done_i (pkt_done_i),
    .cca_idle_i (cca_idle_i),
    .cca_busy_i (cca_busy_i),
    .state_o    (st),
    .ev_o       (ev)
  );

  radio_seq_shorts u_shorts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (short_we_i),
    .wdata_i (short_wdata_i),
    .ev_i    (ev),
    .short_o (short_o),
    .task_o  (sc_task)
  );

  radio_seq_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .evt_clr_i (evt_clr_i),
    .en_set_i  (inten_set_i),
    .en_clr_i  (inten_clr_i),
    .flags_o   (evt_o),
    .inten_o   (inten_o),
    .irq_o     (irq_o)
  );

  assign state_o = st;
endmodule

// File: rtl/radio_seq_checker.sv
module radio_seq_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        task_txen_i,
  input logic        task_rxen_i,
  input logic        task_stop_i,
  input logic        pkt_done_i,
  input logic [31:0] short_o,
  input logic [31:0] inten_set_i,
  input logic [31:0] evt_clr_i,
  input logic [31:0] evt_o,
  input logic        irq_o,
  input logic [3:0]  state_o
);
  assert_state_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd9, 4'd10, 4'd11, 4'd12});

  assert_stop_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd4 || state_o == 4'd12) |=> (state_o == 4'd0));

  assert_disabled_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd4 || state_o == 4'd12) |=> evt_o[4]);

  assert_rx_ready_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd2 && $past(state_o) == 4'd1) |-> (evt_o[0] && evt_o[22]));

  assert_tx_ready_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd10 && $past(state_o) == 4'd9) |-> (evt_o[0] && evt_o[21]));

  assert_end_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 4'd3 && state_o == 4'd2 && !$past(task_stop_i)) |-> evt_o[3]);

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o[3] && !evt_clr_i[3]) |=> evt_o[3]);

  assert_irq_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inten_set_i[3] && evt_o[3] && !evt_clr_i[3]) |=> irq_o);

  assert_off_holds_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd0 && !task_rxen_i && !task_txen_i && short_o[3:2] == 2'b00)
      |=> (state_o == 4'd0));

  assert_end_only_on_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd3 && !pkt_done_i && !evt_o[3]) |=> !evt_o[3]);
endmodule

bind radio_seq radio_seq_checker u_chk (.*);

// File: tb/radio_seq_test.sv
`timescale 1ns/1ps
module radio_seq_test;
  localparam int RAMP = 4;
  localparam int P_TXEN = 1, P_RXEN = 2, P_START = 4, P_STOP = 8, P_DIS = 16,
                 P_CCA = 32, P_DONE = 64, P_CIDLE = 128, P_CBUSY = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic task_txen, task_rxen, task_start, task_stop, task_dis, task_cca;
  logic pkt_done, cca_idle, cca_busy, short_we;
  logic [31:0] short_wdata, short_rd, inten_set, inten_clr, inten_rd, evt_clr, evt;
  logic irq;
  logic [3:0] state;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  // R8 / R7 bit positions
  localparam logic [31:0] EVM = 32'h0066_0019;
  // R9 bit positions
  localparam logic [31:0] SCM = (32'd1<<0)|(32'd1<<1)|(32'd1<<2)|(32'd1<<3)|
                                (32'd1<<5)|(32'd1<<11)|(32'd1<<12)|(32'd1<<19);

  always #4 clk = ~clk;

  radio_seq #(.RAMP_CYCLES(RAMP)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .task_txen_i(task_txen), .task_rxen_i(task_rxen), .task_start_i(task_start),
    .task_stop_i(task_stop), .task_disable_i(task_dis), .task_ccastart_i(task_cca),
    .pkt_done_i(pkt_done), .cca_idle_i(cca_idle), .cca_busy_i(cca_busy),
    .short_we_i(short_we), .short_wdata_i(short_wdata), .short_o(short_rd),
    .inten_set_i(inten_set), .inten_clr_i(inten_clr), .inten_o(inten_rd),
    .evt_clr_i(evt_clr), .evt_o(evt), .irq_o(irq), .state_o(state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    task_txen = 0; task_rxen = 0; task_start = 0; task_stop = 0; task_dis = 0;
    task_cca = 0; pkt_done = 0; cca_idle = 0; cca_busy = 0; short_we = 0;
    short_wdata = '0; inten_set = '0; inten_clr = '0; evt_clr = '0;
  endtask

  task automatic pulse(input int m);
    task_txen  = (m & P_TXEN)  != 0;
    task_rxen  = (m & P_RXEN)  != 0;
    task_start = (m & P_START) != 0;
    task_stop  = (m & P_STOP)  != 0;
    task_dis   = (m & P_DIS)   != 0;
    task_cca   = (m & P_CCA)   != 0;
    pkt_done   = (m & P_DONE)  != 0;
    cca_idle   = (m & P_CIDLE) != 0;
    cca_busy   = (m & P_CBUSY) != 0;
    @(posedge clk); @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear_flags();
    evt_clr = '1; @(posedge clk); @(negedge clk); evt_clr = '0;
  endtask

  task automatic write_short(input logic [31:0] v);
    short_we = 1; short_wdata = v; @(posedge clk); @(negedge clk);
    short_we = 0; short_wdata = '0;
  endtask

  task automatic to_off();
    pulse(P_DIS); step(1); clear_flags();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    step(3);
    // R1 during and after reset
    chk("R1 state", {28'd0, state}, 32'd0);
    chk("R1 flags", evt, 32'd0);
    chk("R1 inten", inten_rd, 32'd0);
    chk("R1 short", short_rd, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rst_ni = 1;
    step(2);
    chk("R1 state after release", {28'd0, state}, 32'd0);

    // R2 receive path with ramp sweep
    pulse(P_RXEN);
    chk("R2 rx ramp entry", {28'd0, state}, 32'd1);
    for (int i = 1; i < RAMP; i++) begin
      step(1);
      chk("R2 rx ramp hold", {28'd0, state}, 32'd1);
      chk("R2 no early flag", evt, 32'd0);
    end
    step(1);
    chk("R2 rx idle", {28'd0, state}, 32'd2);
    chk("R2 ready flags", evt, (32'd1 << 0) | (32'd1 << 22));
    chk("R8 irq stays low unenabled", {31'd0, irq}, 32'd0);
    clear_flags();
    chk("R7 clear", evt, 32'd0);
    pulse(P_START);
    chk("R2 rx active", {28'd0, state}, 32'd3);
    pulse(P_DONE);
    chk("R2 end back to idle", {28'd0, state}, 32'd2);
    chk("R2 end flag", evt, 32'd8);
    step(5);
    chk("R7 sticky", evt, 32'd8);
    pulse(P_STOP);
    chk("R13 stop in idle ignored", {28'd0, state}, 32'd2);
    pulse(P_START);
    pulse(P_STOP);
    chk("R6 stop to idle", {28'd0, state}, 32'd2);
    chk("R6 stop no end", evt, 32'd8);
    clear_flags();
    // R7 event and clear same cycle
    pulse(P_START);
    evt_clr = '1; pkt_done = 1; @(posedge clk); @(negedge clk); idle_inputs();
    chk("R7 event beats clear", evt, 32'd8);
    clear_flags();
    // R5 disable from active
    pulse(P_START);
    pulse(P_DIS);
    chk("R5 rx disabling", {28'd0, state}, 32'd4);
    step(1);
    chk("R5 off", {28'd0, state}, 32'd0);
    chk("R5 disabled flag", evt, 32'd16);
    clear_flags();
    // R13 ignored while off
    pulse(P_START); pulse(P_STOP); pulse(P_CCA); pulse(P_DONE); pulse(P_CIDLE);
    chk("R13 off ignores", {28'd0, state}, 32'd0);
    chk("R13 off no flags", evt, 32'd0);

    // R3 transmit path
    pulse(P_TXEN);
    chk("R3 tx ramp", {28'd0, state}, 32'd9);
    for (int i = 1; i < RAMP; i++) begin
      step(1);
      chk("R3 tx ramp hold", {28'd0, state}, 32'd9);
    end
    step(1);
    chk("R3 tx idle", {28'd0, state}, 32'd10);
    chk("R3 tx flags", evt, (32'd1 << 0) | (32'd1 << 21));
    pulse(P_RXEN);
    chk("R13 rxen in tx idle", {28'd0, state}, 32'd10);
    pulse(P_START);
    chk("R3 tx active", {28'd0, state}, 32'd11);
    pulse(P_DONE);
    chk("R3 tx end", {28'd0, state}, 32'd10);
    chk("R3 end flag", evt, (32'd1 << 0) | (32'd1 << 21) | 32'd8);
    pulse(P_START); pulse(P_STOP);
    chk("R6 tx stop", {28'd0, state}, 32'd10);
    pulse(P_START); pulse(P_DIS);
    chk("R5 tx disabling", {28'd0, state}, 32'd12);
    step(1);
    chk("R5 tx off", {28'd0, state}, 32'd0);
    chk("R5 tx disabled flag", evt[4], 1'b1);
    clear_flags();

    // R12 priorities and turnaround
    pulse(P_TXEN | P_RXEN);
    chk("R12 txen over rxen", {28'd0, state}, 32'd9);
    pulse(P_DIS | P_START);
    chk("R12 disable during ramp", {28'd0, state}, 32'd12);
    step(1); clear_flags();
    pulse(P_RXEN); step(RAMP); pulse(P_START);
    pulse(P_TXEN | P_DONE);
    chk("R12 turnaround from rx", {28'd0, state}, 32'd9);
    step(RAMP);
    chk("R12 turnaround reaches tx idle", {28'd0, state}, 32'd10);
    to_off();

    // R11 clear-channel assessment
    pulse(P_RXEN); step(RAMP); clear_flags();
    pulse(P_CBUSY);
    chk("R11 result without run ignored", evt, 32'd0);
    pulse(P_CCA); pulse(P_CBUSY);
    chk("R11 busy", evt, 32'd1 << 18);
    pulse(P_CCA); pulse(P_CBUSY | P_CIDLE);
    chk("R11 busy wins", evt, 32'd1 << 18);
    clear_flags();
    pulse(P_CCA); pulse(P_CIDLE);
    chk("R11 idle", evt, 32'd1 << 17);
    pulse(P_CCA); pulse(P_DIS); step(1);
    pulse(P_RXEN); step(RAMP); clear_flags();
    pulse(P_CIDLE);
    chk("R11 dropped on leave", evt, 32'd0);

    // R8 enable sweep with known flags (ready + rxready after fresh ramp)
    to_off();
    pulse(P_RXEN); step(RAMP);
    for (int b = 0; b < 32; b++) begin
      logic [31:0] exp_en;
      exp_en = (32'd1 << b) & EVM;
      inten_set = 32'd1 << b; @(posedge clk); @(negedge clk); inten_set = '0;
      chk("R8 set", inten_rd, exp_en);
      chk("R8 irq", {31'd0, irq}, {31'd0, |(exp_en & ((32'd1 << 0) | (32'd1 << 22)))});
      inten_clr = 32'd1 << b; @(posedge clk); @(negedge clk); inten_clr = '0;
      chk("R8 clr", inten_rd, 32'd0);
    end
    inten_set = 32'd8; inten_clr = 32'd8; @(posedge clk); @(negedge clk); idle_inputs();
    chk("R8 set wins", inten_rd, 32'd8);
    clear_flags();
    chk("R8 irq low no flag", {31'd0, irq}, 32'd0);
    pulse(P_START); pulse(P_DONE);
    chk("R8 irq on end", {31'd0, irq}, 32'd1);
    clear_flags();
    chk("R8 irq after clear", {31'd0, irq}, 32'd0);
    inten_clr = '1; @(posedge clk); @(negedge clk); idle_inputs();
    to_off();

    // R9 shortcut readback and chains
    write_short('1);
    chk("R9 readback mask", short_rd, SCM);
    write_short(32'd1 << 0);
    pulse(P_RXEN); step(RAMP);
    chk("R9 ready seen in idle", {28'd0, state}, 32'd2);
    step(1);
    chk("R9 ready->start", {28'd0, state}, 32'd3);
    chk("R10 flag kept", evt, (32'd1 << 0) | (32'd1 << 22));
    write_short(32'd1 << 5);
    pulse(P_DONE);
    chk("R9 end idle", {28'd0, state}, 32'd2);
    step(1);
    chk("R9 end->start", {28'd0, state}, 32'd3);
    write_short('0);
    to_off();

    write_short((32'd1 << 11) | (32'd1 << 12) | (32'd1 << 19));
    pulse(P_RXEN); step(RAMP);
    chk("R9 chain rx idle", {28'd0, state}, 32'd2);
    step(1);
    pulse(P_CIDLE);
    chk("R10 ccaidle flag", evt[17], 1'b1);
    step(1);
    chk("R9 ccaidle->txen", {28'd0, state}, 32'd9);
    step(RAMP);
    chk("R9 chain tx idle", {28'd0, state}, 32'd10);
    step(1);
    chk("R9 txready->start", {28'd0, state}, 32'd11);

    write_short((32'd1 << 1) | (32'd1 << 3));
    pulse(P_DONE);
    chk("R9 tx end", {28'd0, state}, 32'd10);
    step(1);
    chk("R9 end->disable", {28'd0, state}, 32'd12);
    step(1);
    chk("R9 off", {28'd0, state}, 32'd0);
    step(1);
    chk("R9 disabled->rxen", {28'd0, state}, 32'd1);
    write_short('0);
    pulse(P_DIS);
    chk("R5 disable in ramp", {28'd0, state}, 32'd4);
    step(1);
    chk("R5 back off", {28'd0, state}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule